// File: doc/BRIEF.md
# Banked Page-Write Memory Controller

This block is the storage side of a serial configuration memory. A bus decoder upstream turns serial traffic into byte-level requests: load an address, write a byte, read a byte, end a transfer, pick a bank, and set or clear write protection. The block keeps the byte pointer and the active bank. It collects written bytes in a 16-byte page buffer, and on the end-of-transfer request it commits them to a 512-byte store that is built from flops.

The store is split into two banks of 256 bytes, and only the active bank can be reached. Inside a bank, the upper pointer nibble selects one of 16 pages and the lower nibble selects the byte within that page. Byte loads wrap inside the page. Reads walk the whole bank and wrap back to its first byte. Each half of each bank has its own protection flag. A commit that targets a protected half is dropped, and busy stays low for it. A commit that is accepted holds busy high for a programmable number of clocks. While busy is high, the block ignores every request.

Top module: `spd_mem_ctrl`

## Requirements
- R1: After reset the pointer is 0x00, bank 0 is active, all four protection flags are clear, busy is low, and every byte reads 0xFF.
- R2: A request is taken when `req_valid_i` is high and `busy_o` is low. The op codes are 0 set address, 1 write byte, 2 read byte, 3 stop, 4 select bank, 5 set protection, 6 clear protection, and 7 no operation. A read takes the byte at {bank, pointer}, presents it on `rd_data_o` with `rd_valid_o` high in the following cycle, and then advances the pointer by one.
- R3: When a read is taken at pointer 0xFF, the pointer wraps to 0x00 of the same bank.
- R4: A write byte stores its data at buffer offset pointer[3:0] and then advances only pointer[3:0], modulo 16. If more than 16 bytes are loaded, the later bytes overwrite the earlier ones at the same offsets.
- R5: A stop commits only the offsets that were loaded since the last set address. They go to the page that the set address picked, in the bank that was active at that moment. All other bytes of that page keep their values, and memory does not change before the stop.
- R6: A committing stop raises `busy_o` in the next cycle, and `busy_o` then stays high for exactly BUSY_CYCLES cycles.
- R7: While `busy_o` is high, no request has any effect: reads return no data, and the pointer, bank and protection flags stay unchanged.
- R8: Select bank makes bank data[0] the active bank. The two banks hold independent contents.
- R9: Set protection sets the flag numbered data[1:0], and clear protection clears all four flags. `prot_o[i]` is flag i. Block i covers bank i[1], address half i[0], where half 0 is 0x00-0x7F and half 1 is 0x80-0xFF.
- R10: A stop whose target block is protected writes nothing and leaves `busy_o` low.
- R11: A stop with no bytes loaded writes nothing and leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Request op code |
| req_data_i | input | 8 | Address, data, bank or block number |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid |
| busy_o | output | 1 | Write cycle in progress |
| bank_o | output | 1 | Active bank |
| prot_o | output | 4 | Protection flags |

## Verification
The hardest case to reach is the commit of a page that has been overrun. In that case some offsets hold the later of two loads, others hold the only load, and a few were never loaded, and all of this must land in the page that was chosen before a bank switch or a protection change. The bench reaches it with a directed 17-byte load that starts mid-page. It then runs a long random mix of loads, bank switches, protection changes and stops against a bench model of the buffer mask and latched target, so that partial, overrun, rejected and empty commits all occur and are read back.

// File: rtl/spd_mem_pkg.sv
package spd_mem_pkg;
  typedef enum logic [2:0] {
    OP_SET_ADDR = 3'd0,
    OP_WR_BYTE  = 3'd1,
    OP_RD_BYTE  = 3'd2,
    OP_STOP     = 3'd3,
    OP_SET_BANK = 3'd4,
    OP_SET_PROT = 3'd5,
    OP_CLR_PROT = 3'd6,
    OP_NOP      = 3'd7
  } mem_op_e;
endpackage

// File: rtl/spd_page_buf.sv
module spd_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 clr_i,
  input  logic                                 wr_i,
  input  logic [PAGE_W-1:0]                    off_i,
  input  logic [DATA_W-1:0]                    data_i,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]    buf_o,
  output logic [PAGE_BYTES-1:0]                mask_o
);
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr_i) begin
        vld_q  <= 1'b0;
      end else if (wr_i && off_i == PAGE_W'(i)) begin
        byte_q <= data_i;
        vld_q  <= 1'b1;
      end
    end
    assign buf_o[i]  = byte_q;
    assign mask_o[i] = vld_q;
  end
endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int MEM_BYTES  = 2 << ADDR_W,
  localparam int PG_W       = ADDR_W - PAGE_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [ADDR_W:0]                   rd_addr_i,
  output logic [DATA_W-1:0]                 rd_data_o,
  input  logic                              commit_i,
  input  logic [PG_W:0]                     page_i,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] page_data_i,
  input  logic [PAGE_BYTES-1:0]             page_mask_i
);
  logic [DATA_W-1:0] cell_w [MEM_BYTES];

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cell
    localparam logic [PG_W:0]     CellPage = (PG_W+1)'(g >> PAGE_W);
    localparam int                CellOff  = g % PAGE_BYTES;
    logic [DATA_W-1:0] cell_q;
    logic              we;
    assign we = commit_i && (page_i == CellPage) && page_mask_i[CellOff];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cell_q <= '1;  // erased state
      else if (we)  cell_q <= page_data_i[CellOff];
    end
    assign cell_w[g] = cell_q;
  end

  assign rd_data_o = cell_w[rd_addr_i];
endmodule

// File: rtl/spd_busy_timer.sv
module spd_busy_timer #(
  parameter int BUSY_CYCLES = 16,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/spd_mem_ctrl.sv
module spd_mem_ctrl
  import spd_mem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 16,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PG_W       = ADDR_W - PAGE_W,
  localparam int NUM_BLK    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              bank_o,
  output logic [NUM_BLK-1:0] prot_o
);
  mem_op_e op;
  logic    take;
  logic    do_set, do_wr, do_rd, do_stop, do_bank, do_pset, do_pclr;

  logic [ADDR_W-1:0]  ptr_q;
  logic               bank_q;
  logic [NUM_BLK-1:0] prot_q;
  logic [PG_W:0]      tgt_q;   // {bank, page} latched at set address
  logic [DATA_W-1:0]  rd_data_q;
  logic               rd_valid_q;

  logic [PAGE_BYTES-1:0][DATA_W-1:0] pbuf;
  logic [PAGE_BYTES-1:0]             pmask;
  logic [DATA_W-1:0]                 store_rd;
  logic [1:0]                        tgt_blk;
  logic                              commit;

  assign op      = mem_op_e'(req_op_i);
  assign take    = req_valid_i && !busy_o;
  assign do_set  = take && op == OP_SET_ADDR;
  assign do_wr   = take && op == OP_WR_BYTE;
  assign do_rd   = take && op == OP_RD_BYTE;
  assign do_stop = take && op == OP_STOP;
  assign do_bank = take && op == OP_SET_BANK;
  assign do_pset = take && op == OP_SET_PROT;
  assign do_pclr = take && op == OP_CLR_PROT;

  assign tgt_blk = tgt_q[PG_W -: 2];
  assign commit  = do_stop && (|pmask) && !prot_q[tgt_blk];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      bank_q <= 1'b0;
      prot_q <= '0;
      tgt_q  <= '0;
    end else begin
      if (do_set) begin
        ptr_q <= req_data_i[ADDR_W-1:0];
        tgt_q <= {bank_q, req_data_i[ADDR_W-1:PAGE_W]};
      end else if (do_wr) begin
        ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
      end else if (do_rd) begin
        ptr_q <= ptr_q + 1'b1;
      end
      if (do_bank) bank_q <= req_data_i[0];
      if (do_pset) prot_q[req_data_i[1:0]] <= 1'b1;
      else if (do_pclr) prot_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= do_rd;
      if (do_rd) rd_data_q <= store_rd;
    end
  end

  spd_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (do_set || do_stop),
    .wr_i   (do_wr),
    .off_i  (ptr_q[PAGE_W-1:0]),
    .data_i (req_data_i),
    .buf_o  (pbuf),
    .mask_o (pmask)
  );

  spd_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_addr_i   ({bank_q, ptr_q}),
    .rd_data_o   (store_rd),
    .commit_i    (commit),
    .page_i      (tgt_q),
    .page_data_i (pbuf),
    .page_mask_i (pmask)
  );

  spd_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .busy_o  (busy_o)
  );

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  assign bank_o     = bank_q;
  assign prot_o     = prot_q;
endmodule

// File: rtl/spd_mem_ctrl_chk.sv
module spd_mem_ctrl_chk
  import spd_mem_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [2:0] req_op_i,
  input logic       rd_valid_o,
  input logic       busy_o,
  input logic       bank_o,
  input logic [3:0] prot_o
);
  AST_RD_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(req_valid_i && req_op_i == OP_RD_BYTE && !busy_o)); // R2
  AST_BUSY_BLOCKS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_valid_i && req_op_i == OP_RD_BYTE) |=> !rd_valid_o); // R7
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i && req_op_i == OP_STOP)); // R6
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_op_i == OP_SET_BANK && !busy_o) |=> $stable(bank_o)); // R8
  AST_PROT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_op_i == OP_CLR_PROT && !busy_o)
      |=> ((prot_o & $past(prot_o)) == $past(prot_o))); // R9
endmodule

bind spd_mem_ctrl spd_mem_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .rd_valid_o  (rd_valid_o),
  .busy_o      (busy_o),
  .bank_o      (bank_o),
  .prot_o      (prot_o)
);

// File: tb/spd_mem_ctrl_bench.sv
module spd_mem_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [2:0] req_op_i = 3'd7;
  logic [7:0] req_data_i = '0;
  logic [7:0] rd_data_o;
  logic       rd_valid_o, busy_o, bank_o;
  logic [3:0] prot_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mem [512];
  logic [7:0] m_buf [16];
  logic [15:0] m_mask;
  logic [7:0] m_ptr;
  logic       m_bank;
  logic [3:0] m_prot;
  logic [4:0] m_tgt;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spd_mem_ctrl #(.BUSY_CYCLES(BUSY)) u_spd_mem_ctrl (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [7:0] d);
    req_valid_i = 1'b1; req_op_i = o; req_data_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_op_i = 3'd7;
  endtask

  task automatic t_set(input logic [7:0] a);
    issue(3'd0, a);
    m_ptr = a; m_mask = '0; m_tgt = {m_bank, a[7:4]};
  endtask

  task automatic t_wr(input logic [7:0] d);
    issue(3'd1, d);
    m_buf[m_ptr[3:0]] = d; m_mask[m_ptr[3:0]] = 1'b1;
    m_ptr[3:0] = m_ptr[3:0] + 4'd1;
  endtask

  task automatic t_rd(input string tag);
    logic [7:0] e;
    e = m_mem[{m_bank, m_ptr}];
    issue(3'd2, 8'h00);
    m_ptr = m_ptr + 8'd1;
    chk(rd_valid_o === 1'b1 && rd_data_o === e, tag, {rd_valid_o, rd_data_o}, {1'b1, e});
  endtask

  function automatic bit stop_commits();
    return (m_mask != '0) && !m_prot[m_tgt[4:3]];
  endfunction

  task automatic model_commit();
    if (stop_commits())
      for (int i = 0; i < 16; i++)
        if (m_mask[i]) m_mem[{m_tgt, i[3:0]}] = m_buf[i];
    m_mask = '0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (busy_o === 1'b1 && n < 1000) begin n++; @(negedge clk_i); end
    chk(n == BUSY, tag, n, BUSY);
  endtask

  task automatic t_stop(input string tag);
    bit e;
    e = stop_commits();
    issue(3'd3, 8'h00);
    model_commit();
    chk(busy_o === e, tag, busy_o, e);
    if (e) drain({tag, " R6 busy length"});
  endtask

  task automatic t_bank(input logic b);
    issue(3'd4, {7'd0, b}); m_bank = b;
  endtask

  task automatic t_pset(input logic [1:0] b);
    issue(3'd5, {6'd0, b}); m_prot[b] = 1'b1;
  endtask

  task automatic t_pclr();
    issue(3'd6, 8'h00); m_prot = '0;
  endtask

  task automatic read_page(input logic [7:0] base, input string tag);
    t_set(base);
    for (int i = 0; i < 16; i++) t_rd(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 512; i++) m_mem[i] = 8'hFF;
    m_mask = '0; m_ptr = '0; m_bank = 1'b0; m_prot = '0; m_tgt = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(busy_o === 1'b0, "R1 busy", busy_o, 0);
    chk(bank_o === 1'b0, "R1 bank", bank_o, 0);
    chk(prot_o === 4'h0, "R1 prot", prot_o, 0);
    chk(rd_valid_o === 1'b0, "R1 rd_valid", rd_valid_o, 0);
    t_rd("R1 erased byte at 0x00");
    t_rd("R2 pointer advance");

    // R11 empty stop
    t_stop("R11 empty stop");

    // R4 R5 17-byte overrun starting mid-page
    t_set(8'h35);
    for (int i = 0; i < 17; i++) t_wr(8'h10 + 8'(i));
    chk(m_mem[9'h035] === 8'hFF, "R5 model pre-stop", m_mem[9'h035], 8'hFF);
    t_stop("R4 overrun stop");
    read_page(8'h30, "R4 overrun page readback");
    // R5 partial page leaves the rest untouched
    t_set(8'h48);
    for (int i = 0; i < 3; i++) t_wr(8'hA0 + 8'(i));
    t_stop("R5 partial stop");
    read_page(8'h40, "R5 partial page readback");

    // R3 bank-end wrap
    t_set(8'hF0); t_wr(8'h5A); t_stop("R3 setup");
    t_set(8'h00); t_wr(8'hC3); t_stop("R3 setup");
    t_set(8'hFE);
    t_rd("R3 byte 0xFE"); t_rd("R3 byte 0xFF"); t_rd("R3 wrap to 0x00");

    // R8 bank switch
    t_bank(1'b1);
    chk(bank_o === 1'b1, "R8 bank_o", bank_o, 1);
    t_set(8'h35); t_wr(8'h77); t_wr(8'h88); t_stop("R8 bank1 write");
    t_set(8'h35); t_rd("R8 bank1 data"); t_rd("R8 bank1 data");
    t_bank(1'b0);
    t_set(8'h35); t_rd("R8 bank0 untouched");

    // R9 R10 each protected block
    for (int b = 0; b < 4; b++) begin
      t_pclr();
      t_pset(2'(b));
      chk(prot_o === 4'(1 << b), "R9 flag position", prot_o, 1 << b);
      t_bank(b[1]);
      t_set(b[0] ? 8'h92 : 8'h12);
      t_wr(8'hE0 + 8'(b)); t_wr(8'hE8 + 8'(b));
      t_stop("R10 protected stop no busy");
      read_page(b[0] ? 8'h90 : 8'h10, "R10 protected page unchanged");
      t_set(b[0] ? 8'h12 : 8'h92);
      t_wr(8'h30 + 8'(b));
      t_stop("R9 other half commits");
      read_page(b[0] ? 8'h10 : 8'h90, "R9 other half readback");
    end
    t_pclr();
    chk(prot_o === 4'h0, "R9 clear all", prot_o, 0);

    // R7 requests while busy are ignored
    t_bank(1'b0);
    t_set(8'h60); t_wr(8'h42);
    issue(3'd3, 8'h00);
    model_commit();
    chk(busy_o === 1'b1, "R7 busy up", busy_o, 1);
    issue(3'd2, 8'h00);
    chk(rd_valid_o === 1'b0, "R7 read ignored", rd_valid_o, 0);
    issue(3'd0, 8'hC0);
    issue(3'd4, 8'h01);
    issue(3'd5, 8'h02);
    chk(bank_o === 1'b0 && prot_o === 4'h0, "R7 bank/prot held", {bank_o, prot_o}, 0);
    while (busy_o === 1'b1) @(negedge clk_i);
    t_rd("R7 pointer held");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 2)        t_set(8'($urandom));
      else if (r < 7)   t_wr(8'($urandom));
      else if (r < 11)  t_rd("R2 random read");
      else if (r < 13)  t_stop("R5 random stop");
      else if (r == 13) t_bank(1'($urandom));
      else if (r == 14) t_pset(2'($urandom));
      else              t_pclr();
    end
    chk(bank_o === m_bank && prot_o === m_prot, "R8 random state", {bank_o, prot_o}, {m_bank, m_prot});

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule